// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor that runs one instruction at a time through a fixed sequence of fetch, decode and execute steps. Its state is a program counter, an instruction register, a single 8-bit accumulator and a saved-return-address register. Each instruction is 16 bits wide. The 8-bit memory port brings the instruction in as two single-byte reads, and the same port serves the data reads and writes.

The instruction set loads a constant, adds a memory byte, stores the accumulator, and provides an unconditional jump, a jump when the accumulator is zero, a halt and a software trap. Three events send execution to a fixed handler address: the trap, an undefined opcode, and an attempt to fetch from outside the program window. The trap saves the address of the instruction that follows it, so the handler can return past it. A fault saves the address of the offending instruction, so it can be executed again. The decoder is pure combinational logic, and a small state machine runs the sequence.

Top module: `acc_cpu`

## Requirements
- R1: After the second instruction byte has been fetched, and before the instruction executes, the program counter advances by 2.
- R2: The instruction register does not change while an instruction is in its execute phase or in its memory-wait phase.
- R3: The byte at the program counter forms bits [7:0] of the instruction and the byte at the next address forms bits [15:8]. Bits [15:12] hold the opcode and bits [7:0] hold the operand. Opcodes are 0 halt, 1 load-constant, 2 add-memory, 3 store, 4 jump, 5 jump-if-zero and 6 trap.
- R4: Load-constant sets the accumulator to the operand. Add-memory adds the byte at the operand address modulo 256. Store writes the accumulator to the operand address. The memory port is synchronous: read data appears on the cycle after the read strobe.
- R5: Jump sets the program counter to the operand. Jump-if-zero does the same only when the accumulator is zero; otherwise execution continues with the next instruction.
- R6: Halt stops execution. From then until reset the program counter holds its value and the core makes no memory access.
- R7: The trap (opcode 6) saves the address of the instruction after it and continues at the handler address, 0x80 by default.
- R8: Opcodes 7 to 15 raise a fault. The fault saves the address of the offending instruction and continues at the handler address.
- R9: A fetch from an address whose second byte lies at or above the program limit (0xC0 by default) raises a fault. The fault saves that fetch address and continues at the handler address.
- R10: Every instruction takes 4 cycles, except add-memory, which takes 5. A rejected fetch takes 1 cycle.
- R11: During reset the program counter, the accumulator and the saved return address are 0, the core is not halted and no write is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 8 | Byte address for the current access |
| mem_re | output | 1 | Read strobe; data returns on the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data (the accumulator) |
| mem_rdata | input | 8 | Read data from the previous cycle's read |
| acc_o | output | 8 | Accumulator value |
| pc_o | output | 8 | Program counter value |
| epc_o | output | 8 | Saved return address |
| halted_o | output | 1 | Core has stopped |

## Verification
One small program containing arithmetic, a store and a conditional branch is run with five constant/memory-byte pairs. A zero sum, a nonzero sum, and sums that wrap past 255 to zero select different branch outcomes and different cycle totals, which separates a correct zero test and correct modular addition from wrong ones. Separate directed programs reach the handler by each of its three routes. The saved address tells apart "instruction after the trap" (trap), "offending instruction" (undefined opcode) and "fetch address" (program-window fault). A halt test confirms that the program counter stays frozen afterwards.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPW = 4;

   localparam logic [OPW-1:0] OPC_HALT = 4'd0;
   localparam logic [OPW-1:0] OPC_LDI  = 4'd1;
   localparam logic [OPW-1:0] OPC_ADDM = 4'd2;
   localparam logic [OPW-1:0] OPC_STA  = 4'd3;
   localparam logic [OPW-1:0] OPC_JMP  = 4'd4;
   localparam logic [OPW-1:0] OPC_JZ   = 4'd5;
   localparam logic [OPW-1:0] OPC_SYS  = 4'd6;

   typedef enum logic [2:0] {
      ST_FETCH_LO,
      ST_FETCH_HI,
      ST_DECODE,
      ST_EXECUTE,
      ST_MEM_WAIT,
      ST_HALTED
   } cpu_state_e;

   typedef struct packed {
      logic ld_imm;
      logic add_mem;
      logic store;
      logic jump;
      logic jump_z;
      logic sys;
      logic halt;
      logic illegal;
   } ctl_t;

endpackage

// File: rtl/acc_cpu_decoder.sv
module acc_cpu_decoder
   import acc_cpu_pkg::*;
(
   input  logic [OPW-1:0] opcode_i,
   output ctl_t           ctl_o
);

   always_comb begin
      ctl_o = '0;
      case (opcode_i)
         OPC_HALT: ctl_o.halt    = 1'b1;
         OPC_LDI:  ctl_o.ld_imm  = 1'b1;
         OPC_ADDM: ctl_o.add_mem = 1'b1;
         OPC_STA:  ctl_o.store   = 1'b1;
         OPC_JMP:  ctl_o.jump    = 1'b1;
         OPC_JZ:   ctl_o.jump_z  = 1'b1;
         OPC_SYS:  ctl_o.sys     = 1'b1;
         default:  ctl_o.illegal = 1'b1;
      endcase
   end

endmodule

// File: rtl/acc_cpu_irreg.sv
module acc_cpu_irreg #(
   parameter int DW    = 8,
   parameter int NLANE = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NLANE-1:0]    lane_we,
   input  logic [DW-1:0]       din,
   output logic [NLANE*DW-1:0] ir_o
);

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      logic [DW-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n)          lane_q <= '0;
         else if (lane_we[g]) lane_q <= din;
      end
      assign ir_o[g*DW +: DW] = lane_q;
   end

   AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_we)); // R3

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int AW           = 8,
   parameter int DW           = 8,
   parameter int IW           = 16,
   parameter int RESET_PC     = 0,
   parameter int HANDLER_ADDR = 128,
   parameter int PROG_TOP     = 192
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [AW-1:0] mem_addr,
   output logic          mem_re,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] acc_o,
   output logic [AW-1:0] pc_o,
   output logic [AW-1:0] epc_o,
   output logic          halted_o
);

   localparam int NLANE = IW / DW;
   localparam logic [AW-1:0] HANDLER = AW'(HANDLER_ADDR);
   localparam logic [AW-1:0] PC_INIT = AW'(RESET_PC);
   localparam logic [AW:0]   TOP     = (AW+1)'(PROG_TOP);
   localparam logic [AW-1:0] STEP    = AW'(NLANE);

   if (NLANE != 2 || IW != NLANE * DW) begin : g_bad_width
      $error("instruction must be exactly two data bytes");
   end
   if (AW > IW - OPW || DW > IW - OPW) begin : g_bad_field
      $error("operand does not fit below the opcode");
   end
   if (PROG_TOP > (1 << AW) || HANDLER_ADDR + NLANE > PROG_TOP) begin : g_bad_map
      $error("handler must sit inside the program window");
   end

   cpu_state_e     st_q;
   logic [AW-1:0]  pc_q;
   logic [AW-1:0]  epc_q;
   logic [DW-1:0]  acc_q;
   logic [IW-1:0]  ir;
   logic [NLANE-1:0] lane_we;
   ctl_t           ctl;
   logic           pc_bad;
   logic [AW-1:0]  opnd;

   assign opnd   = ir[AW-1:0];
   assign pc_bad = ({1'b0, pc_q} + {{AW{1'b0}}, 1'b1}) >= TOP;

   if (AW < IW - OPW) begin : g_spare
      logic spare_unused;
      assign spare_unused = ^ir[IW-OPW-1:AW];
   end

   assign lane_we[0] = (st_q == ST_FETCH_HI);
   assign lane_we[1] = (st_q == ST_DECODE);

   acc_cpu_irreg #(.DW(DW), .NLANE(NLANE)) u_ir (
      .clk     (clk),
      .rst_n   (rst_n),
      .lane_we (lane_we),
      .din     (mem_rdata),
      .ir_o    (ir)
   );

   acc_cpu_decoder u_dec (
      .opcode_i (ir[IW-1 -: OPW]),
      .ctl_o    (ctl)
   );

   always_comb begin
      mem_addr  = pc_q;
      mem_re    = 1'b0;
      mem_we    = 1'b0;
      mem_wdata = acc_q;
      case (st_q)
         ST_FETCH_LO: mem_re = !pc_bad;
         ST_FETCH_HI: begin
            mem_addr = pc_q + AW'(1);
            mem_re   = 1'b1;
         end
         ST_EXECUTE: begin
            mem_addr = opnd;
            mem_re   = ctl.add_mem;
            mem_we   = ctl.store;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_FETCH_LO;
         pc_q  <= PC_INIT;
         epc_q <= '0;
         acc_q <= '0;
      end else begin
         case (st_q)
            ST_FETCH_LO: begin
               if (pc_bad) begin
                  epc_q <= pc_q;
                  pc_q  <= HANDLER;
               end else begin
                  st_q <= ST_FETCH_HI;
               end
            end
            ST_FETCH_HI: st_q <= ST_DECODE;
            ST_DECODE: begin
               pc_q <= pc_q + STEP;
               st_q <= ST_EXECUTE;
            end
            ST_EXECUTE: begin
               st_q <= ST_FETCH_LO;
               if (ctl.illegal) begin
                  epc_q <= pc_q - STEP;
                  pc_q  <= HANDLER;
               end else if (ctl.halt) begin
                  st_q <= ST_HALTED;
               end else if (ctl.sys) begin
                  epc_q <= pc_q;
                  pc_q  <= HANDLER;
               end else if (ctl.ld_imm) begin
                  acc_q <= ir[DW-1:0];
               end else if (ctl.add_mem) begin
                  st_q <= ST_MEM_WAIT;
               end else if (ctl.jump) begin
                  pc_q <= opnd;
               end else if (ctl.jump_z) begin
                  if (acc_q == '0) pc_q <= opnd;
               end
            end
            ST_MEM_WAIT: begin
               acc_q <= acc_q + mem_rdata;
               st_q  <= ST_FETCH_LO;
            end
            default: st_q <= ST_HALTED;
         endcase
      end
   end

   assign acc_o    = acc_q;
   assign pc_o     = pc_q;
   assign epc_o    = epc_q;
   assign halted_o = (st_q == ST_HALTED);

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DECODE) |=> (pc_q == $past(pc_q) + STEP)); // R1
   AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_EXECUTE) |=> $stable(ir)); // R2
   AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we)); // R4
   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HALTED) |=> (st_q == ST_HALTED && $stable(pc_q) && !mem_we && !mem_re)); // R6
   AST_SYS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_EXECUTE && ctl.sys) |=> (pc_q == HANDLER && epc_q == $past(pc_q))); // R7
   AST_FAULT_EPC: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_EXECUTE && ctl.illegal) |=> (pc_q == HANDLER && epc_q == $past(pc_q) - STEP)); // R8
   AST_BAD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FETCH_LO && pc_bad) |=> (pc_q == HANDLER && epc_q == $past(pc_q))); // R9

endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] mem_addr, mem_wdata, acc_o, pc_o, epc_o;
   logic       mem_re, mem_we, halted_o;
   logic [7:0] rdata_q = 8'h00;
   logic [7:0] mem [0:255];

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   acc_cpu uut (
      .clk (clk), .rst_n (rst_n),
      .mem_addr (mem_addr), .mem_re (mem_re), .mem_we (mem_we),
      .mem_wdata (mem_wdata), .mem_rdata (rdata_q),
      .acc_o (acc_o), .pc_o (pc_o), .epc_o (epc_o), .halted_o (halted_o)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) rdata_q <= mem[mem_addr];
   end

   // Each entry: constant k in [15:8], memory byte m in [7:0]
   localparam logic [15:0] VEC [5] = '{16'h0000, 16'h0507, 16'hFF01, 16'h8080, 16'h1234};

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic enter_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
   endtask

   task automatic put16(input int a, input logic [15:0] w);
      mem[a]     = w[7:0];
      mem[a + 1] = w[15:8];
   endtask

   task automatic load_handler();
      put16(8'h80, 16'h30F2);   // store to F2
      put16(8'h82, 16'h0000);   // halt
   endtask

   task automatic run(output int cyc);
      @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
      while (!halted_o && cyc < 2000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int cyc;
      int k, m, sum, flag;
      logic [7:0] held_pc;

      // R11: reset state
      enter_reset();
      @(negedge clk);
      check("R11 pc", pc_o, 0);
      check("R11 acc", acc_o, 0);
      check("R11 epc", epc_o, 0);
      check("R11 halted", halted_o, 0);
      check("R11 write", mem_we, 0);

      // Table walk: R3 R4 R5 R10
      foreach (VEC[i]) begin
         k = VEC[i][15:8];
         m = VEC[i][7:0];
         sum = (k + m) & 8'hFF;
         flag = (sum == 0) ? 8'hAA : 8'h55;
         enter_reset();
         put16(8'h00, {8'h10, VEC[i][15:8]});
         put16(8'h02, 16'h20E0);
         put16(8'h04, 16'h30E1);
         put16(8'h06, 16'h500C);
         put16(8'h08, 16'h1055);
         put16(8'h0A, 16'h400E);
         put16(8'h0C, 16'h10AA);
         put16(8'h0E, 16'h30F0);
         put16(8'h10, 16'h0000);
         mem[8'hE0] = VEC[i][7:0];
         run(cyc);
         check("R4 sum stored", mem[8'hE1], sum);
         check("R5 branch path", mem[8'hF0], flag);
         check("R10 cycles", cyc, (sum == 0) ? 29 : 33);
         check("R1 final pc", pc_o, 8'h12);
      end

      // R6 halt hold and R10 basic timing
      enter_reset();
      put16(8'h00, 16'h105A);
      put16(8'h02, 16'h0000);
      run(cyc);
      check("R10 ldi+halt cycles", cyc, 8);
      check("R4 ldi value", acc_o, 8'h5A);
      held_pc = pc_o;
      repeat (10) @(negedge clk);
      check("R6 pc held", pc_o, held_pc);
      check("R6 still halted", halted_o, 1);

      // R7 trap
      enter_reset();
      load_handler();
      put16(8'h00, 16'h1003);
      put16(8'h02, 16'h6000);
      put16(8'h04, 16'h0000);
      run(cyc);
      check("R7 epc", epc_o, 8'h04);
      check("R7 handler store", mem[8'hF2], 8'h03);
      check("R7 pc", pc_o, 8'h84);
      check("R10 trap cycles", cyc, 16);

      // R8 undefined opcode
      enter_reset();
      load_handler();
      put16(8'h00, 16'h1009);
      put16(8'h02, 16'hF000);
      run(cyc);
      check("R8 epc", epc_o, 8'h02);
      check("R8 handler store", mem[8'hF2], 8'h09);

      // R9 fetch outside program window
      enter_reset();
      load_handler();
      mem[8'hF2] = 8'h77;
      put16(8'h00, 16'h40C8);
      run(cyc);
      check("R9 epc", epc_o, 8'hC8);
      check("R9 handler store", mem[8'hF2], 8'h00);
      check("R10 rejected fetch cycles", cyc, 13);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule